// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Round-Robin Unit Choice

This block sits between instruction dispatch and a set of execution units. Each dispatched instruction brings an age tag, two source register tags with ready flags, and the index of the resource group it needs. The instruction takes a free buffer entry. It waits there until both sources are available, which happens either at dispatch or later through a result-broadcast bus. Once both sources are available it becomes a candidate for issue.

Each cycle, every resource group issues at most one candidate. The candidate picked is the oldest among the ready entries of that group. The unit it goes to is picked round-robin among the group's free units. An issued entry then counts down the fixed latency of its group. When the count ends it reports completion on that unit's completion port and frees its entry. While no entry is free, a full flag tells dispatch to hold.

Top module: `ooo_issue_sched`

## Requirements
- R1: An instruction whose two ready flags are both set at dispatch may issue in the cycle after dispatch, never in the dispatch cycle itself.
- R2: A source that is not ready at dispatch becomes ready only when a later broadcast carries its tag. A broadcast seen before the dispatch cycle is not remembered. The instruction issues at the earliest in the cycle after the broadcast that completes its sources.
- R3: A broadcast whose tag matches a source in the same cycle as that instruction's dispatch marks the source ready.
- R4: Among the ready entries of one group, the oldest issues first. Age `a` is older than age `b` when `(a - b)` modulo 2^AGE_W has its top bit set. This holds whichever buffer slot each entry occupies.
- R5: Group g owns units g*UNITS_PER_GRP to g*UNITS_PER_GRP+UNITS_PER_GRP-1. The unit search starts after the unit last granted in that group and takes the first free unit in cyclic order. After reset the search starts at the lowest unit of the group.
- R6: A unit is never chosen while its `unit_busy` bit is high. It is also never chosen while an instruction issued to it has not yet completed, and that includes the completion cycle.
- R7: An instruction issued in cycle t raises `done_valid[u]` for its unit u in cycle t+L, where L is the field `GRP_LAT[g*LAT_W +: LAT_W]` of its group g. `done_age[u]` carries its age in that cycle.
- R8: `full` is high exactly when all entries are occupied. A dispatch offered while `full` is high is dropped and never issues. An entry becomes free in the cycle after its completion.
- R9: Each group issues at most one instruction per cycle. Different groups issue independently in the same cycle, and the unit an instruction issues to always belongs to its own group.
- R10: During and right after reset, no issue or completion is signalled and `full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_age | input | AGE_W | Program-order age tag |
| disp_src_a | input | TAG_W | First source register tag |
| disp_rdy_a | input | 1 | First source already available |
| disp_src_b | input | TAG_W | Second source register tag |
| disp_rdy_b | input | 1 | Second source already available |
| disp_grp | input | GIDX_W | Required resource group |
| full | output | 1 | No free entry; dispatch is dropped |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Produced register tag |
| unit_busy | input | NUNIT | Per-unit external busy |
| iss_valid | output | NGROUP | Per-group issue strobe |
| iss_age | output | NGROUP*AGE_W | Age of the issued instruction, per group |
| iss_unit | output | NGROUP*UIDX_W | Global index of the chosen unit, per group |
| done_valid | output | NUNIT | Per-unit completion strobe |
| done_age | output | NUNIT*AGE_W | Age of the completing instruction, per unit |

## Verification
The checker assumes that every dispatched group index names an existing group. It also assumes that the ages in flight are distinct and span less than half the age range, so the modular age compare stays meaningful. The bench keeps to both rules. It uses only groups 0 and 1, with at most eight live ages at a time, including a run of ages across the 31-to-0 wrap. It never dispatches a second instruction with the age of one still in flight.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_READY = 2'd2,
      SLOT_EXEC  = 2'd3
   } slot_state_e;

endpackage

// File: rtl/sched_slot.sv
module sched_slot #(
   parameter int TAG_W  = 5,
   parameter int AGE_W  = 5,
   parameter int GIDX_W = 1,
   parameter int UIDX_W = 2,
   parameter int LAT_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc,
   input  logic [AGE_W-1:0]        a_age,
   input  logic [TAG_W-1:0]        a_src_a,
   input  logic                    a_rdy_a,
   input  logic [TAG_W-1:0]        a_src_b,
   input  logic                    a_rdy_b,
   input  logic [GIDX_W-1:0]       a_grp,
   input  logic                    wb_valid,
   input  logic [TAG_W-1:0]        wb_tag,
   input  logic                    grant,
   input  logic [UIDX_W-1:0]       g_unit,
   input  logic [LAT_W-1:0]        g_lat,
   output sched_pkg::slot_state_e  st,
   output logic [AGE_W-1:0]        age,
   output logic [GIDX_W-1:0]       grp,
   output logic [UIDX_W-1:0]       unit,
   output logic                    done
);
   import sched_pkg::*;

   logic [TAG_W-1:0] src_a, src_b;
   logic             rdy_a, rdy_b;
   logic [LAT_W-1:0] cnt;
   logic             nxt_a, nxt_b, new_a, new_b;

   always_comb begin
      nxt_a = rdy_a | (wb_valid && wb_tag == src_a);
      nxt_b = rdy_b | (wb_valid && wb_tag == src_b);
      new_a = a_rdy_a | (wb_valid && wb_tag == a_src_a);
      new_b = a_rdy_b | (wb_valid && wb_tag == a_src_b);
   end

   assign done = (st == SLOT_EXEC) && (cnt <= LAT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= SLOT_FREE;
         age   <= '0;
         grp   <= '0;
         unit  <= '0;
         src_a <= '0;
         src_b <= '0;
         rdy_a <= 1'b0;
         rdy_b <= 1'b0;
         cnt   <= '0;
      end else begin
         case (st)
            SLOT_FREE: begin
               if (alloc) begin
                  age   <= a_age;
                  grp   <= a_grp;
                  src_a <= a_src_a;
                  src_b <= a_src_b;
                  rdy_a <= new_a;
                  rdy_b <= new_b;
                  st    <= (new_a && new_b) ? SLOT_READY : SLOT_WAIT;
               end
            end
            SLOT_WAIT: begin
               rdy_a <= nxt_a;
               rdy_b <= nxt_b;
               if (nxt_a && nxt_b) st <= SLOT_READY;
            end
            SLOT_READY: begin
               if (grant) begin
                  st   <= SLOT_EXEC;
                  unit <= g_unit;
                  cnt  <= g_lat;
               end
            end
            SLOT_EXEC: begin
               if (cnt <= LAT_W'(1)) st <= SLOT_FREE;
               else                  cnt <= cnt - LAT_W'(1);
            end
            default: st <= SLOT_FREE;
         endcase
      end
   end

endmodule

// File: rtl/sched_oldest.sv
module sched_oldest #(
   parameter int N     = 8,
   parameter int AGE_W = 5,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]       req,
   input  logic [N*AGE_W-1:0] ages,
   output logic               pick_v,
   output logic [IDX_W-1:0]   pick_idx
);
   logic [AGE_W-1:0] best;
   logic [AGE_W-1:0] diff;

   always_comb begin
      pick_v   = 1'b0;
      pick_idx = '0;
      best     = '0;
      diff     = '0;
      for (int i = 0; i < N; i++) begin
         diff = ages[i*AGE_W +: AGE_W] - best;
         if (req[i] && (!pick_v || diff[AGE_W-1])) begin
            pick_v   = 1'b1;
            pick_idx = IDX_W'(i);
            best     = ages[i*AGE_W +: AGE_W];
         end
      end
   end

endmodule

// File: rtl/sched_rr.sv
module sched_rr #(
   parameter int N     = 2,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     avail,
   input  logic             take,
   output logic             pick_v,
   output logic [IDX_W-1:0] pick
);
   generate
      if (N == 1) begin : g_single
         assign pick_v = avail[0];
         assign pick   = '0;
      end else begin : g_multi
         logic [IDX_W-1:0] last;

         always_comb begin
            pick_v = 1'b0;
            pick   = '0;
            for (int k = 1; k <= N; k++) begin
               if (!pick_v && avail[(int'(last) + k) % N]) begin
                  pick_v = 1'b1;
                  pick   = IDX_W'((int'(last) + k) % N);
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    last <= IDX_W'(N - 1);
            else if (take) last <= pick;
         end
      end
   endgenerate

endmodule

// File: rtl/ooo_issue_sched.sv
module ooo_issue_sched #(
   parameter int ENTRIES       = 8,
   parameter int TAG_W         = 5,
   parameter int AGE_W         = 5,
   parameter int NGROUP        = 2,
   parameter int UNITS_PER_GRP = 2,
   parameter int LAT_W         = 4,
   parameter logic [NGROUP*LAT_W-1:0] GRP_LAT = {4'd3, 4'd1},
   localparam int NUNIT  = NGROUP * UNITS_PER_GRP,
   localparam int EIDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int UIDX_W = (NUNIT > 1) ? $clog2(NUNIT) : 1,
   localparam int GIDX_W = (NGROUP > 1) ? $clog2(NGROUP) : 1,
   localparam int LIDX_W = (UNITS_PER_GRP > 1) ? $clog2(UNITS_PER_GRP) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      disp_valid,
   input  logic [AGE_W-1:0]          disp_age,
   input  logic [TAG_W-1:0]          disp_src_a,
   input  logic                      disp_rdy_a,
   input  logic [TAG_W-1:0]          disp_src_b,
   input  logic                      disp_rdy_b,
   input  logic [GIDX_W-1:0]         disp_grp,
   output logic                      full,
   input  logic                      wb_valid,
   input  logic [TAG_W-1:0]          wb_tag,
   input  logic [NUNIT-1:0]          unit_busy,
   output logic [NGROUP-1:0]         iss_valid,
   output logic [NGROUP*AGE_W-1:0]   iss_age,
   output logic [NGROUP*UIDX_W-1:0]  iss_unit,
   output logic [NUNIT-1:0]          done_valid,
   output logic [NUNIT*AGE_W-1:0]    done_age
);
   import sched_pkg::*;

   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("ENTRIES must be at least 2");
      end
      if (UNITS_PER_GRP < 1 || NGROUP < 1) begin : g_bad_units
         $error("need at least one group and one unit per group");
      end
      if ((2 ** AGE_W) < 2 * ENTRIES) begin : g_bad_age
         $error("AGE_W too narrow for ordered compare over ENTRIES");
      end
      for (genvar c = 0; c < NGROUP; c++) begin : g_lat_chk
         if (GRP_LAT[c*LAT_W +: LAT_W] == 0) begin : g_zero
            $error("group latency must be at least 1");
         end
      end
   endgenerate

   slot_state_e        st     [ENTRIES];
   logic [AGE_W-1:0]   s_age  [ENTRIES];
   logic [GIDX_W-1:0]  s_grp  [ENTRIES];
   logic [UIDX_W-1:0]  s_unit [ENTRIES];
   logic [ENTRIES-1:0] s_done;
   logic [ENTRIES-1:0] free_v;
   logic [ENTRIES-1:0] alloc_v;
   logic [ENTRIES-1:0] grant_v;
   logic [UIDX_W-1:0]  g_unit [ENTRIES];
   logic [LAT_W-1:0]   g_lat  [ENTRIES];
   logic [ENTRIES*AGE_W-1:0] age_flat;

   logic [EIDX_W-1:0]  alloc_idx;
   logic               alloc_hit;
   logic [NUNIT-1:0]   occ;
   logic [NUNIT-1:0]   unit_free;
   logic [EIDX_W-1:0]  pick_idx [NGROUP];
   logic [UIDX_W-1:0]  iss_unit_a [NGROUP];

   // allocation: lowest free entry
   always_comb begin
      alloc_idx = '0;
      alloc_hit = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (!alloc_hit && free_v[e]) begin
            alloc_idx = EIDX_W'(e);
            alloc_hit = 1'b1;
         end
      end
   end

   assign full = ~|free_v;

   // unit occupancy from executing entries
   always_comb begin
      occ = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (st[e] == SLOT_EXEC) occ[s_unit[e]] = 1'b1;
      end
   end

   assign unit_free = ~unit_busy & ~occ;

   // grant routing back to the winning entries
   always_comb begin
      grant_v = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         for (int g = 0; g < NGROUP; g++) begin
            if (iss_valid[g] && pick_idx[g] == EIDX_W'(e)) grant_v[e] = 1'b1;
         end
      end
   end

   // completion per unit
   always_comb begin
      done_valid = '0;
      done_age   = '0;
      for (int u = 0; u < NUNIT; u++) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (s_done[e] && s_unit[e] == UIDX_W'(u)) begin
               done_valid[u]               = 1'b1;
               done_age[u*AGE_W +: AGE_W]  = s_age[e];
            end
         end
      end
   end

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
         assign free_v[e]  = (st[e] == SLOT_FREE);
         assign alloc_v[e] = disp_valid && !full && alloc_hit && (alloc_idx == EIDX_W'(e));
         assign age_flat[e*AGE_W +: AGE_W] = s_age[e];
         assign g_unit[e]  = iss_unit_a[s_grp[e]];
         assign g_lat[e]   = GRP_LAT[s_grp[e]*LAT_W +: LAT_W];

         sched_slot #(
            .TAG_W  (TAG_W),
            .AGE_W  (AGE_W),
            .GIDX_W (GIDX_W),
            .UIDX_W (UIDX_W),
            .LAT_W  (LAT_W)
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_v[e]),
            .a_age    (disp_age),
            .a_src_a  (disp_src_a),
            .a_rdy_a  (disp_rdy_a),
            .a_src_b  (disp_src_b),
            .a_rdy_b  (disp_rdy_b),
            .a_grp    (disp_grp),
            .wb_valid (wb_valid),
            .wb_tag   (wb_tag),
            .grant    (grant_v[e]),
            .g_unit   (g_unit[e]),
            .g_lat    (g_lat[e]),
            .st       (st[e]),
            .age      (s_age[e]),
            .grp      (s_grp[e]),
            .unit     (s_unit[e]),
            .done     (s_done[e])
         );
      end

      for (genvar g = 0; g < NGROUP; g++) begin : g_grp
         logic [ENTRIES-1:0] req;
         logic               old_v;
         logic               rr_v;
         logic [LIDX_W-1:0]  rr_sel;

         for (genvar e = 0; e < ENTRIES; e++) begin : g_req
            assign req[e] = (st[e] == SLOT_READY) && (s_grp[e] == GIDX_W'(g));
         end

         sched_oldest #(
            .N     (ENTRIES),
            .AGE_W (AGE_W),
            .IDX_W (EIDX_W)
         ) u_old (
            .req      (req),
            .ages     (age_flat),
            .pick_v   (old_v),
            .pick_idx (pick_idx[g])
         );

         sched_rr #(
            .N     (UNITS_PER_GRP),
            .IDX_W (LIDX_W)
         ) u_rr (
            .clk    (clk),
            .rst_n  (rst_n),
            .avail  (unit_free[g*UNITS_PER_GRP +: UNITS_PER_GRP]),
            .take   (iss_valid[g]),
            .pick_v (rr_v),
            .pick   (rr_sel)
         );

         assign iss_valid[g]   = old_v && rr_v;
         assign iss_unit_a[g]  = UIDX_W'(g * UNITS_PER_GRP) + UIDX_W'(rr_sel);
         assign iss_unit[g*UIDX_W +: UIDX_W] = iss_unit_a[g];
         assign iss_age[g*AGE_W +: AGE_W]    = s_age[pick_idx[g]];
      end
   endgenerate

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
   parameter int ENTRIES       = 8,
   parameter int NGROUP        = 2,
   parameter int UNITS_PER_GRP = 2,
   parameter int UIDX_W        = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     disp_valid,
   input logic                     full,
   input logic [NGROUP*UNITS_PER_GRP-1:0] unit_busy,
   input logic [NGROUP-1:0]        iss_valid,
   input logic [NGROUP*UIDX_W-1:0] iss_unit,
   input logic [NGROUP*UNITS_PER_GRP-1:0] done_valid
);
   localparam int NU  = NGROUP * UNITS_PER_GRP;
   localparam int CW  = $clog2(ENTRIES + 1);

   logic [NU-1:0] issued_to;
   logic [NU-1:0] outst;
   logic [CW-1:0] live;

   always_comb begin
      issued_to = '0;
      for (int g = 0; g < NGROUP; g++) begin
         if (iss_valid[g]) issued_to[iss_unit[g*UIDX_W +: UIDX_W]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst <= '0;
         live  <= '0;
      end else begin
         outst <= (outst & ~done_valid) | issued_to;
         live  <= live + CW'(disp_valid && !full) - CW'($countones(done_valid));
      end
   end

   // R8
   full_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full == (live == CW'(ENTRIES)));

   generate
      for (genvar u = 0; u < NU; u++) begin : g_u
         // R6
         unit_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issued_to[u] |-> !outst[u]);
         // R7
         done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_valid[u] |-> outst[u]);
      end
      for (genvar g = 0; g < NGROUP; g++) begin : g_g
         // R9
         grp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[g] |-> (int'(iss_unit[g*UIDX_W +: UIDX_W]) / UNITS_PER_GRP == g));
         // R6
         busy_honor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[g] |-> !unit_busy[iss_unit[g*UIDX_W +: UIDX_W]]);
      end
   endgenerate

endmodule

bind ooo_issue_sched sched_chk #(
   .ENTRIES       (ENTRIES),
   .NGROUP        (NGROUP),
   .UNITS_PER_GRP (UNITS_PER_GRP),
   .UIDX_W        (UIDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_valid (disp_valid),
   .full       (full),
   .unit_busy  (unit_busy),
   .iss_valid  (iss_valid),
   .iss_unit   (iss_unit),
   .done_valid (done_valid)
);

// File: tb/tb_ooo_issue_sched.sv
`timescale 1ns/1ps
module tb_ooo_issue_sched;
   localparam int TAG_W = 5;
   localparam int AGE_W = 5;
   localparam int LAT0  = 1;
   localparam int LAT1  = 3;

   typedef struct {
      int age;
      int unit;
      int cyc;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              disp_valid = 1'b0;
   logic [AGE_W-1:0]  disp_age = '0;
   logic [TAG_W-1:0]  disp_src_a = '0;
   logic              disp_rdy_a = 1'b0;
   logic [TAG_W-1:0]  disp_src_b = '0;
   logic              disp_rdy_b = 1'b0;
   logic              disp_grp = 1'b0;
   logic              full;
   logic              wb_valid = 1'b0;
   logic [TAG_W-1:0]  wb_tag = '0;
   logic [3:0]        unit_busy = '0;
   logic [1:0]        iss_valid;
   logic [9:0]        iss_age;
   logic [3:0]        iss_unit;
   logic [3:0]        done_valid;
   logic [19:0]       done_age;

   ooo_issue_sched #(
      .ENTRIES(8), .TAG_W(TAG_W), .AGE_W(AGE_W), .NGROUP(2),
      .UNITS_PER_GRP(2), .LAT_W(4), .GRP_LAT({4'd3, 4'd1})
   ) dut (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_age(disp_age),
      .disp_src_a(disp_src_a), .disp_rdy_a(disp_rdy_a),
      .disp_src_b(disp_src_b), .disp_rdy_b(disp_rdy_b), .disp_grp(disp_grp),
      .full(full), .wb_valid(wb_valid), .wb_tag(wb_tag), .unit_busy(unit_busy),
      .iss_valid(iss_valid), .iss_age(iss_age), .iss_unit(iss_unit),
      .done_valid(done_valid), .done_age(done_age)
   );

   always #5 clk = ~clk;

   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    fin = 1'b0;
   string cur_req = "R1";
   item_t q0[$];
   item_t q1[$];
   int    iss_cyc [32];
   int    iss_u   [32];
   bit    pend    [32];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next();
      @(posedge clk);
      #1;
      disp_valid = 1'b0;
      wb_valid   = 1'b0;
   endtask

   task automatic disp(int age, int sa, bit ra, int sb, bit rb, bit grp);
      disp_valid = 1'b1;
      disp_age   = AGE_W'(age);
      disp_src_a = TAG_W'(sa);
      disp_rdy_a = ra;
      disp_src_b = TAG_W'(sb);
      disp_rdy_b = rb;
      disp_grp   = grp;
   endtask

   task automatic bcast(int tag);
      wb_valid = 1'b1;
      wb_tag   = TAG_W'(tag);
   endtask

   // driver side of the scoreboard
   task automatic expect_iss(int g, int age, int unit, int at);
      item_t it;
      it.age = age; it.unit = unit; it.cyc = at;
      if (g == 0) q0.push_back(it);
      else        q1.push_back(it);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      unit_busy = '0;
      repeat (2) next();
      rst_n = 1'b1;
      next();
   endtask

   // monitor side of the scoreboard
   item_t it_m;
   bit    got_m;
   int    a_m, u_m, l_m;
   always @(negedge clk) begin
      if (rst_n && !fin) begin
         for (int g = 0; g < 2; g++) begin
            if (iss_valid[g]) begin
               a_m = int'(iss_age[g*AGE_W +: AGE_W]);
               u_m = int'(iss_unit[g*2 +: 2]);
               got_m = 1'b0;
               if (g == 0 && q0.size() > 0) begin it_m = q0.pop_front(); got_m = 1'b1; end
               if (g == 1 && q1.size() > 0) begin it_m = q1.pop_front(); got_m = 1'b1; end
               if (!got_m) begin
                  check(1'b0, cur_req, "unexpected issue age", a_m, -1);
               end else begin
                  check(a_m == it_m.age,  cur_req, "issue age",  a_m, it_m.age);
                  check(u_m == it_m.unit, cur_req, "issue unit", u_m, it_m.unit);
                  check(cyc == it_m.cyc,  cur_req, "issue cycle", cyc, it_m.cyc);
               end
               iss_cyc[a_m] = cyc;
               iss_u[a_m]   = u_m;
               pend[a_m]    = 1'b1;
            end
         end
         for (int u = 0; u < 4; u++) begin
            if (done_valid[u]) begin
               a_m = int'(done_age[u*AGE_W +: AGE_W]);
               l_m = (u < 2) ? LAT0 : LAT1;
               check(pend[a_m], "R7", "completion without issue age", a_m, a_m);
               check(iss_u[a_m] == u, "R7", "completion unit", u, iss_u[a_m]);
               check(cyc == iss_cyc[a_m] + l_m, "R7", "completion cycle", cyc, iss_cyc[a_m] + l_m);
               pend[a_m] = 1'b0;
            end
         end
      end
   end

   task automatic finish_run();
      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      check(1'b0, "R10", "watchdog expired cycle", cyc, 0);
      finish_run();
   end

   int d;
   initial begin
      for (int i = 0; i < 32; i++) begin pend[i] = 1'b0; iss_cyc[i] = 0; iss_u[i] = 0; end

      // R10: reset state
      rst_n = 1'b0;
      repeat (2) next();
      #3;
      check(iss_valid == 2'b00, "R10", "iss_valid in reset", int'(iss_valid), 0);
      check(done_valid == 4'b0, "R10", "done_valid in reset", int'(done_valid), 0);
      check(full == 1'b0, "R10", "full in reset", int'(full), 0);
      rst_n = 1'b1;
      next();
      #3;
      check(iss_valid == 2'b00 && done_valid == 4'b0 && !full, "R10", "idle after reset", 0, 0);

      // R1/R5: ready at dispatch, group 0
      cur_req = "R1/R5";
      next(); d = cyc;
      disp(1, 1, 1, 2, 1, 0); expect_iss(0, 1, 0, d + 1);
      next(); disp(2, 1, 1, 2, 1, 0); expect_iss(0, 2, 1, d + 2);
      next(); disp(3, 1, 1, 2, 1, 0); expect_iss(0, 3, 0, d + 3);
      repeat (8) next();

      // R2/R4/R6: waiting on a tag, group 1 with latency 3
      do_reset(); cur_req = "R2/R4/R6";
      d = cyc;
      disp(7, 10, 0, 2, 1, 1);
      next(); disp(8, 10, 0, 2, 1, 1);
      next(); disp(9, 10, 0, 2, 1, 1);
      next(); next(); bcast(10);
      expect_iss(1, 7, 2, d + 5);
      expect_iss(1, 8, 3, d + 6);
      expect_iss(1, 9, 2, d + 9);
      repeat (12) next();

      // R3 and R2: same-cycle broadcast counts, earlier one does not
      do_reset(); cur_req = "R3/R2";
      d = cyc;
      disp(4, 12, 0, 2, 1, 0); bcast(12); expect_iss(0, 4, 0, d + 1);
      next(); bcast(14);
      next(); disp(5, 2, 1, 14, 0, 0);
      next(); next(); next(); bcast(14); expect_iss(0, 5, 1, d + 6);
      repeat (8) next();

      // R4: age wrap, older entry in higher slot
      do_reset(); cur_req = "R4";
      d = cyc;
      disp(30, 1, 1, 2, 1, 0); expect_iss(0, 30, 0, d + 1);
      next(); disp(31, 3, 0, 2, 1, 0);
      next();
      next(); disp(0, 3, 0, 2, 1, 0);
      next(); next(); bcast(3);
      expect_iss(0, 31, 1, d + 6);
      expect_iss(0, 0, 0, d + 7);
      repeat (8) next();

      // R6/R9: external busy, independent groups
      do_reset(); cur_req = "R6/R9";
      unit_busy = 4'b0100;
      d = cyc;
      disp(6, 1, 1, 2, 1, 1); expect_iss(1, 6, 3, d + 1);
      next(); disp(7, 1, 1, 2, 1, 1);
      next(); disp(9, 1, 1, 2, 1, 0);
      next(); unit_busy = 4'b0000;
      expect_iss(1, 7, 2, d + 3);
      expect_iss(0, 9, 0, d + 3);
      repeat (8) next();

      // R8: full buffer drops dispatch
      do_reset(); cur_req = "R8";
      d = cyc;
      for (int i = 0; i < 8; i++) begin
         if (i > 0) next();
         disp(10 + i, 15, 0, 2, 1, 0);
         expect_iss(0, 10 + i, i % 2, d + 10 + i);
      end
      next(); #3;
      check(full == 1'b1, "R8", "full with all entries held", int'(full), 1);
      disp(18, 1, 1, 2, 1, 0);
      next(); bcast(15);
      next(); next(); next(); #3;
      check(full == 1'b0, "R8", "full after first release", int'(full), 0);
      repeat (12) next();

      // R5: rotation when both units of the group are free
      do_reset(); cur_req = "R5";
      d = cyc;
      disp(20, 1, 1, 2, 1, 1); expect_iss(1, 20, 2, d + 1);
      repeat (6) next(); disp(21, 1, 1, 2, 1, 1); expect_iss(1, 21, 3, d + 7);
      repeat (6) next(); disp(22, 1, 1, 2, 1, 1); expect_iss(1, 22, 2, d + 13);
      repeat (10) next();

      check(q0.size() == 0, "R9", "group 0 issues missing", q0.size(), 0);
      check(q1.size() == 0, "R9", "group 1 issues missing", q1.size(), 0);
      begin
         int np;
         np = 0;
         for (int i = 0; i < 32; i++) if (pend[i]) np++;
         check(np == 0, "R7", "completions missing", np, 0);
      end
      finish_run();
   end

endmodule